// File: doc/BRIEF.md
# Self-Timed Page Program Sequencer

This block sits behind the serial protocol engine of a paged nonvolatile memory. When the engine sees the bus stop condition after a write transfer, it hands over one request. The request carries the page buffer (one byte per page slot), a mask that marks which slots the host actually sent, the page number, the offset of the last byte entered, the level of the hardware write-protect pin and the protection flag of the target page. If nothing forbids the write, the sequencer runs a self-timed cycle in two phases. In the first phase every selected slot is set to all ones. In the second phase each selected slot is loaded with its buffered byte. Slots that were not selected are never touched.

Throughout the cycle `busy` stays high, and the protocol engine uses it to withhold its acknowledge from new command bytes. A single-cycle `done` marks the end of the cycle. The two phase lengths are parameters counted in system clocks, so the millisecond timing can be scaled down for simulation. The address counter output keeps the last byte address entered, both during and after the cycle. A request that is suppressed, or that carries no data, produces no busy period at all.

Top module: `pgm_seq`

## Requirements
- R1: A request with a nonzero mask, `req_wp`=0 and `req_locked`=0, sampled while `busy` is low, raises `busy` on the next cycle and keeps it high for exactly ERASE_CYC+WRITE_CYC cycles.
- R2: Erase phase: for each slot i (byte i is `req_data[8i+7:8i]`, selected by `req_mask[i]`) that is selected, `mem_we` is high with `mem_wdata`=8'hFF and `mem_addr`={page,i} in cycle i+1 after acceptance (acceptance cycle = 0), in ascending slot order.
- R3: Write phase: each selected slot i is written with its buffered byte at `mem_addr`={page,i} in cycle ERASE_CYC+1+i after acceptance.
- R4: Unselected slots and all other addresses are never written, and `mem_we` is low outside the cycles named in R2 and R3.
- R5: `done` is high for exactly one cycle, in cycle ERASE_CYC+WRITE_CYC after acceptance, which is the first cycle in which `busy` is low again.
- R6: With `req_wp`=1 the request produces no busy period, no write and no `done`.
- R7: With `req_locked`=1 the request produces no busy period, no write and no `done`.
- R8: A request with an all-zero mask starts no cycle and leaves `last_addr` unchanged.
- R9: `last_addr` resets to 0. One cycle after any request with a nonzero mask that is sampled while `busy` is low, whether it is suppressed or not, it holds {`req_page`,`req_last`}, and it keeps that value until the next such request.
- R10: A request sampled while `busy` is high is ignored: `last_addr` does not change, and the writes and the end state of memory are those of the cycle already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe issued at the stop condition |
| req_page | input | PAGE_AW | Target page number |
| req_last | input | OFF_W | Offset of the last byte entered |
| req_mask | input | PAGE_BYTES | Per-slot select mask |
| req_data | input | 8*PAGE_BYTES | Page buffer, slot i in bits 8i+7:8i |
| req_wp | input | 1 | Hardware write-protect level |
| req_locked | input | 1 | Target page is protected |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | PAGE_AW+OFF_W | Array byte address |
| mem_wdata | output | 8 | Array write data |
| last_addr | output | PAGE_AW+OFF_W | Address counter, last byte entered |

## Verification
All results are counted from the cycle in which the request is sampled, which is cycle 0. `busy` and `last_addr` change from cycle 0. The erase write for slot i is due in cycle i+1, the data write in cycle ERASE_CYC+1+i, and `done` in cycle ERASE_CYC+WRITE_CYC. The bench drives each request on a falling edge and then samples every output on each following falling edge, so every offset it tests is a whole number of register stages after the sampling edge. Across a sweep of all 256 masks it compares every sampled cycle with the expected pattern for that offset, and it compares the whole memory model after each cycle.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } phase_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pgm_admit.sv
module pgm_admit #(
  parameter int PAGE_BYTES = 32,
  parameter int PAGE_AW    = 8,
  parameter int OFF_W      = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [PAGE_AW-1:0]       req_page,
  input  logic [OFF_W-1:0]         req_last,
  input  logic [PAGE_BYTES-1:0]    req_mask,
  input  logic                     req_wp,
  input  logic                     req_locked,
  input  logic                     busy,
  output logic                     start,
  output logic [PAGE_AW+OFF_W-1:0] last_addr
);
  logic taken;

  // a request counts only while idle and only when it brought data
  assign taken = req_valid && !busy && (|req_mask);
  assign start = taken && !req_wp && !req_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
    end else if (taken) begin
      last_addr <= {req_page, req_last};
    end
  end
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer
  import pgm_seq_pkg::*;
#(
  parameter int ERASE_CYC = 200,
  parameter int WRITE_CYC = 300,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ERASE_END = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] WRITE_END = CNT_W'(WRITE_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ERASE;
            cnt   <= '0;
            busy  <= 1'b1;
          end
        end
        PH_ERASE: begin
          if (cnt == ERASE_END) begin
            phase <= PH_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (cnt == WRITE_END) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgm_wport.sv
module pgm_wport
  import pgm_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int PAGE_AW    = 8,
  parameter int OFF_W      = 5,
  parameter int CNT_W      = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  phase_t                    phase,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [PAGE_BYTES-1:0]     sel_mask,
  input  logic [PAGE_BYTES*8-1:0]   sel_data,
  input  logic [PAGE_AW-1:0]        sel_page,
  output logic                      mem_we,
  output logic [PAGE_AW+OFF_W-1:0]  mem_addr,
  output logic [7:0]                mem_wdata
);
  logic [7:0]       slot [PAGE_BYTES];
  logic [OFF_W-1:0] idx;
  logic             in_page;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign slot[g] = sel_data[8*g +: 8];
  end

  assign idx     = cnt[OFF_W-1:0];
  assign in_page = (cnt < CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= (phase != PH_IDLE) && in_page && sel_mask[idx];
      mem_addr  <= {sel_page, idx};
      mem_wdata <= (phase == PH_ERASE) ? ERASED_BYTE : slot[idx];
    end
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int PAGES      = 256,
  parameter int ERASE_CYC  = 200,
  parameter int WRITE_CYC  = 300,
  parameter int PAGE_AW    = $clog2(PAGES),
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [PAGE_AW-1:0]        req_page,
  input  logic [OFF_W-1:0]          req_last,
  input  logic [PAGE_BYTES-1:0]     req_mask,
  input  logic [PAGE_BYTES*8-1:0]   req_data,
  input  logic                      req_wp,
  input  logic                      req_locked,
  output logic                      busy,
  output logic                      done,
  output logic                      mem_we,
  output logic [PAGE_AW+OFF_W-1:0]  mem_addr,
  output logic [7:0]                mem_wdata,
  output logic [PAGE_AW+OFF_W-1:0]  last_addr
);
  localparam int MAX_CYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic                    start;
  phase_t                  phase;
  logic [CNT_W-1:0]        cnt;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_AW-1:0]      buf_page;

  pgm_admit #(.PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .OFF_W(OFF_W)) u_admit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_page(req_page),
    .req_last(req_last), .req_mask(req_mask), .req_wp(req_wp),
    .req_locked(req_locked), .busy(busy), .start(start), .last_addr(last_addr)
  );

  // page buffer snapshot held for the whole cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_mask <= '0;
      buf_data <= '0;
      buf_page <= '0;
    end else if (start) begin
      buf_mask <= req_mask;
      buf_data <= req_data;
      buf_page <= req_page;
    end
  end

  pgm_timer #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .cnt(cnt),
    .busy(busy), .done(done)
  );

  pgm_wport #(.PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .OFF_W(OFF_W),
              .CNT_W(CNT_W)) u_wport (
    .clk(clk), .rst(rst), .phase(phase), .cnt(cnt), .sel_mask(buf_mask),
    .sel_data(buf_data), .sel_page(buf_page), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int PAGE_BYTES = 32,
  parameter int PAGE_AW    = 8,
  parameter int OFF_W      = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [PAGE_BYTES-1:0]    req_mask,
  input logic                     req_wp,
  input logic                     req_locked,
  input logic                     busy,
  input logic                     done,
  input logic                     mem_we,
  input logic [PAGE_AW+OFF_W-1:0] last_addr
);
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && (|req_mask) && !req_wp && !req_locked) |=> busy);

  p_we_in_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(busy));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_wp) |=> !busy);

  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_locked) |=> !busy);

  p_empty_no_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && (req_mask == '0)) |=> (!busy && $stable(last_addr)));

  p_addr_held_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(last_addr));
endmodule

bind pgm_seq pgm_seq_chk #(.PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mask(req_mask),
  .req_wp(req_wp), .req_locked(req_locked), .busy(busy), .done(done),
  .mem_we(mem_we), .last_addr(last_addr)
);

// File: tb/tb_pgm_seq.sv
module tb_pgm_seq;
  localparam int NB    = 8;
  localparam int NP    = 4;
  localparam int ER    = 10;
  localparam int WR    = 12;
  localparam int PAW   = 2;
  localparam int OW    = 3;
  localparam int AW    = PAW + OW;
  localparam int EW    = ER + WR;
  localparam int MEMSZ = NB * NP;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic [PAW-1:0]  req_page;
  logic [OW-1:0]   req_last;
  logic [NB-1:0]   req_mask;
  logic [NB*8-1:0] req_data;
  logic            req_wp;
  logic            req_locked;
  logic            busy, done, mem_we;
  logic [AW-1:0]   mem_addr, last_addr;
  logic [7:0]      mem_wdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [MEMSZ];
  logic [7:0] expm [MEMSZ];
  int exp_addr = 0;

  always #2.5 clk = ~clk;

  pgm_seq #(.PAGE_BYTES(NB), .PAGES(NP), .ERASE_CYC(ER), .WRITE_CYC(WR)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_page(req_page),
    .req_last(req_last), .req_mask(req_mask), .req_data(req_data),
    .req_wp(req_wp), .req_locked(req_locked), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .last_addr(last_addr)
  );

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) ^ (seed >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic drive(input int page, input int mask, input int last, input int seed,
                       input bit wp, input bit lk);
    req_valid  = 1'b1;
    req_page   = PAW'(page);
    req_mask   = NB'(mask);
    req_last   = OW'(last);
    req_wp     = wp;
    req_locked = lk;
    for (int i = 0; i < NB; i++) req_data[8*i +: 8] = dbyte(seed, i);
  endtask

  task automatic run_op(input int page, input int mask, input int last, input bit wp,
                        input bit lk, input bit intrude, input string sup_tag);
    bit run;
    int base;
    bit ewe;
    int eslot;
    logic [7:0] ed;
    run  = (mask != 0) && !wp && !lk;
    base = page * NB;
    @(negedge clk);
    drive(page, mask, last, page + mask, wp, lk);
    if (mask != 0) exp_addr = page * NB + last;
    for (int t = 0; t <= EW + 2; t++) begin
      @(negedge clk);
      ewe = 1'b0; eslot = 0; ed = 8'h00;
      if (run && t >= 1 && t <= NB && mask[t-1]) begin
        ewe = 1'b1; eslot = t - 1; ed = 8'hFF;
      end
      if (run && t >= ER + 1 && t <= ER + NB && mask[t-1-ER]) begin
        ewe = 1'b1; eslot = t - 1 - ER; ed = dbyte(page + mask, t - 1 - ER);
      end
      chk(busy == (run && t < EW), run ? "R1" : sup_tag, int'(busy), int'(run && t < EW));
      chk(done == (run && t == EW), run ? "R5" : sup_tag, int'(done), int'(run && t == EW));
      if (run && t >= 1 && t <= NB)
        chk(mem_we == ewe, "R2", int'(mem_we), int'(ewe));
      else if (run && t >= ER + 1 && t <= ER + NB)
        chk(mem_we == ewe, "R3", int'(mem_we), int'(ewe));
      else
        chk(mem_we == 1'b0, run ? "R4" : sup_tag, int'(mem_we), 0);
      if (ewe && mem_we) begin
        chk(int'(mem_addr) == base + eslot, (ed == 8'hFF && t <= NB) ? "R2" : "R3",
            int'(mem_addr), base + eslot);
        chk(mem_wdata == ed, (t <= NB) ? "R2" : "R3", int'(mem_wdata), int'(ed));
      end
      if (mem_we) mdl[int'(mem_addr)] = mem_wdata;
      if (t == 0) begin
        req_valid = 1'b0;
        chk(int'(last_addr) == exp_addr, (mask == 0) ? "R8" : "R9",
            int'(last_addr), exp_addr);
      end
      if (intrude && t == 2) drive((page + 1) % NP, (~mask) & 8'hFF, (last + 3) % NB, 99, 0, 0);
      if (intrude && t == 3) req_valid = 1'b0;
    end
    chk(int'(last_addr) == exp_addr, intrude ? "R10" : "R9", int'(last_addr), exp_addr);
    if (run)
      for (int i = 0; i < NB; i++)
        if (mask[i]) expm[base + i] = dbyte(page + mask, i);
    for (int a = 0; a < MEMSZ; a++)
      chk(mdl[a] === expm[a], intrude ? "R10" : "R4", int'(mdl[a]), int'(expm[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int a = 0; a < MEMSZ; a++) begin
      mdl[a]  = 8'h5A;
      expm[a] = 8'h5A;
    end
    rst = 1'b1; req_valid = 1'b0; req_page = '0; req_last = '0; req_mask = '0;
    req_data = '0; req_wp = 1'b0; req_locked = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R5", int'(done), 0);
    chk(mem_we == 1'b0, "R4", int'(mem_we), 0);
    chk(last_addr == '0, "R9", int'(last_addr), 0);

    // full sweep of every mask; mask 0 exercises R8
    for (int m = 0; m < 256; m++)
      run_op(m % NP, m, (m * 5) % NB, 1'b0, 1'b0, 1'b0, "R8");

    run_op(2, 8'hA5, 6, 1'b1, 1'b0, 1'b0, "R6");
    run_op(3, 8'hFF, 1, 1'b0, 1'b1, 1'b0, "R7");
    run_op(0, 8'h81, 4, 1'b1, 1'b1, 1'b0, "R6");
    run_op(1, 8'h3C, 2, 1'b0, 1'b0, 1'b1, "R10");
    run_op(3, 8'h00, 7, 1'b0, 1'b0, 1'b0, "R8");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule